// File: doc/BRIEF.md
# Sticky Fatal Error Code Aggregator

This block collects fault indications from around an entropy-distribution datapath and turns them into one sticky error-code word. Three FIFOs report their full and empty flags and their read and write strobes. The block classifies each fault by type: a write into a full FIFO, a read from an empty FIFO, or a FIFO that shows full and empty at the same time. Each fault sets two bits: one that names the FIFO and one shared bit that names the kind of fault. Two state machines and one hardened counter report illegal-state and count errors directly.

Every bit in the error word stays set until the next reset. While any bit is set, the block holds a fatal alert and a fatal interrupt high. Software can also inject an error. It writes a 5-bit bit number through a test strobe, and the block treats that as a single-cycle error pulse at that position. The injected pulse reaches the alert and the interrupt along the same path as a real fault. Bit numbers that name no implemented error bit are discarded.

Top module: `err_code_aggregator`

## Requirements
- R1: While `rst_i` is high, the block clears `err_code_o`, `alert_fatal_o` and `irq_fatal_o` to zero at each clock edge.
- R2: A write strobe to a FIFO whose full flag is set in the same cycle sets bit 28 and that FIFO's source bit at the next clock edge. FIFO index 0 is the reseed FIFO and maps to bit 0. Index 1 is the generate FIFO and maps to bit 1. Index 2 is the output FIFO and maps to bit 2.
- R3: A read strobe to a FIFO whose empty flag is set in the same cycle sets bit 29 and that FIFO's source bit at the next clock edge.
- R4: A FIFO that shows full and empty in the same cycle sets bit 30 and that FIFO's source bit at the next clock edge, whether or not it is strobed.
- R5: The acknowledge state-machine error sets bit 20, the main state-machine error sets bit 21, and the counter error sets bit 22, each at the next clock edge.
- R6: Once set, an error bit stays set until reset, and errors from different cycles accumulate in the word.
- R7: When `inj_we_i` is high and `inj_sel_i` holds one of the implemented positions (0, 1, 2, 20, 21, 22, 28, 29, 30), the block sets exactly that bit at the next clock edge. An injection into a type bit sets no source bit.
- R8: An injection with any other bit number leaves `err_code_o` unchanged. The reserved positions of `err_code_o` always read zero.
- R9: `alert_fatal_o` is high in exactly those cycles in which `err_code_o` is non-zero.
- R10: `irq_fatal_o` is high in exactly those cycles in which `err_code_o` is non-zero.
- R11: A write to a FIFO that is not full, or a read from a FIFO that is not empty, sets no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fifo_full_i | input | 3 | Per-FIFO full flag (0 reseed, 1 generate, 2 output) |
| fifo_empty_i | input | 3 | Per-FIFO empty flag |
| fifo_rd_i | input | 3 | Per-FIFO read strobe |
| fifo_wr_i | input | 3 | Per-FIFO write strobe |
| ack_sm_err_i | input | 1 | Acknowledge state machine illegal-state flag |
| main_sm_err_i | input | 1 | Main state machine illegal-state flag |
| cntr_err_i | input | 1 | Hardened counter error flag |
| inj_we_i | input | 1 | Error injection strobe |
| inj_sel_i | input | 5 | Bit number to inject |
| err_code_o | output | 32 | Sticky error code word |
| alert_fatal_o | output | 1 | Fatal alert, level |
| irq_fatal_o | output | 1 | Fatal interrupt, level |

## Verification
The assertions check several properties on every cycle. They check that set bits never fall, that reserved positions stay zero, and that each fault class lands in its bit one edge after the cause. They also check that both outputs track a non-zero word exactly, and that reset clears everything. The bench scenarios cover what no single property captures. These are the exact composition of the word after mixed random faults across many cycles, the rejection of every reserved injection number, and the absence of side effects from legal FIFO traffic.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;

  localparam int unsigned ERR_W    = 32;
  localparam int unsigned SEL_W    = 5;

  // Fixed positions decoded by the register readback
  localparam int unsigned POS_ACK_SM  = 20;
  localparam int unsigned POS_MAIN_SM = 21;
  localparam int unsigned POS_CNTR    = 22;
  localparam int unsigned POS_T_WR    = 28;
  localparam int unsigned POS_T_RD    = 29;
  localparam int unsigned POS_T_ST    = 30;

  typedef struct packed {
    logic both_flags;
    logic rd_empty;
    logic wr_full;
  } fault_kind_t;

  function automatic logic [ERR_W-1:0] impl_mask(input int unsigned n_fifo);
    logic [ERR_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(n_fifo); i++) m[i] = 1'b1;
    m[POS_ACK_SM]  = 1'b1;
    m[POS_MAIN_SM] = 1'b1;
    m[POS_CNTR]    = 1'b1;
    m[POS_T_WR]    = 1'b1;
    m[POS_T_RD]    = 1'b1;
    m[POS_T_ST]    = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/fifo_fault_classifier.sv
module fifo_fault_classifier
  import err_agg_pkg::*;
#(
  parameter int unsigned NUM_FIFOS = 3
) (
  input  logic [NUM_FIFOS-1:0] full_i,
  input  logic [NUM_FIFOS-1:0] empty_i,
  input  logic [NUM_FIFOS-1:0] rd_i,
  input  logic [NUM_FIFOS-1:0] wr_i,
  output logic [NUM_FIFOS-1:0] src_o,
  output fault_kind_t          kind_o
);

  fault_kind_t per_fifo [NUM_FIFOS];

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_fifo
    always_comb begin
      per_fifo[g].wr_full    = wr_i[g] & full_i[g];
      per_fifo[g].rd_empty   = rd_i[g] & empty_i[g];
      per_fifo[g].both_flags = full_i[g] & empty_i[g];
    end
    assign src_o[g] = |per_fifo[g];
  end

  always_comb begin
    kind_o = '0;
    for (int i = 0; i < int'(NUM_FIFOS); i++) begin
      kind_o = kind_o | per_fifo[i];
    end
  end

endmodule

// File: rtl/err_inject_decoder.sv
module err_inject_decoder #(
  parameter int unsigned      ERR_W = 32,
  parameter int unsigned      SEL_W = 5,
  parameter logic [ERR_W-1:0] MASK  = '1
) (
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [ERR_W-1:0] pulse_o
);

  logic [ERR_W-1:0] onehot;

  for (genvar b = 0; b < ERR_W; b++) begin : g_dec
    assign onehot[b] = we_i && (int'(sel_i) == b);
  end

  assign pulse_o = onehot & MASK;

endmodule

// File: rtl/sticky_err_reg.sv
module sticky_err_reg #(
  parameter int unsigned      ERR_W = 32,
  parameter logic [ERR_W-1:0] MASK  = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [ERR_W-1:0] set_i,
  output logic [ERR_W-1:0] q_o
);

  for (genvar b = 0; b < ERR_W; b++) begin : g_bit
    if (MASK[b]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i) begin
        if (rst_i)         q <= 1'b0;
        else if (set_i[b]) q <= 1'b1;
      end
      assign q_o[b] = q;
    end else begin : g_rsvd
      assign q_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/fatal_out_stage.sv
module fatal_out_stage #(
  parameter int unsigned ERR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [ERR_W-1:0] held_i,
  input  logic [ERR_W-1:0] new_i,
  output logic             alert_o,
  output logic             irq_o
);

  logic any_next;
  assign any_next = |(held_i | new_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      alert_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      alert_o <= any_next;
      irq_o   <= any_next;
    end
  end

endmodule

// File: rtl/err_code_aggregator.sv
module err_code_aggregator
  import err_agg_pkg::*;
#(
  parameter int unsigned NUM_FIFOS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [NUM_FIFOS-1:0] fifo_full_i,
  input  logic [NUM_FIFOS-1:0] fifo_empty_i,
  input  logic [NUM_FIFOS-1:0] fifo_rd_i,
  input  logic [NUM_FIFOS-1:0] fifo_wr_i,
  input  logic                 ack_sm_err_i,
  input  logic                 main_sm_err_i,
  input  logic                 cntr_err_i,
  input  logic                 inj_we_i,
  input  logic [SEL_W-1:0]     inj_sel_i,
  output logic [ERR_W-1:0]     err_code_o,
  output logic                 alert_fatal_o,
  output logic                 irq_fatal_o
);

  localparam logic [ERR_W-1:0] MASK = impl_mask(NUM_FIFOS);

  logic [NUM_FIFOS-1:0] src;
  fault_kind_t          kind;
  logic [ERR_W-1:0]     inj_pulse;
  logic [ERR_W-1:0]     hw_set;
  logic [ERR_W-1:0]     set_vec;

  fifo_fault_classifier #(.NUM_FIFOS(NUM_FIFOS)) u_cls (
    .full_i (fifo_full_i),
    .empty_i(fifo_empty_i),
    .rd_i   (fifo_rd_i),
    .wr_i   (fifo_wr_i),
    .src_o  (src),
    .kind_o (kind)
  );

  err_inject_decoder #(.ERR_W(ERR_W), .SEL_W(SEL_W), .MASK(MASK)) u_inj (
    .we_i   (inj_we_i),
    .sel_i  (inj_sel_i),
    .pulse_o(inj_pulse)
  );

  always_comb begin
    hw_set                = '0;
    hw_set[NUM_FIFOS-1:0] = src;
    hw_set[POS_ACK_SM]    = ack_sm_err_i;
    hw_set[POS_MAIN_SM]   = main_sm_err_i;
    hw_set[POS_CNTR]      = cntr_err_i;
    hw_set[POS_T_WR]      = kind.wr_full;
    hw_set[POS_T_RD]      = kind.rd_empty;
    hw_set[POS_T_ST]      = kind.both_flags;
  end

  assign set_vec = hw_set | inj_pulse;

  sticky_err_reg #(.ERR_W(ERR_W), .MASK(MASK)) u_reg (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .set_i(set_vec),
    .q_o  (err_code_o)
  );

  fatal_out_stage #(.ERR_W(ERR_W)) u_out (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .held_i (err_code_o),
    .new_i  (set_vec),
    .alert_o(alert_fatal_o),
    .irq_o  (irq_fatal_o)
  );

endmodule

// File: rtl/err_code_aggregator_chk.sv
module err_code_aggregator_chk
  import err_agg_pkg::*;
#(
  parameter int unsigned NUM_FIFOS = 3
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic [NUM_FIFOS-1:0] fifo_full_i,
  input logic [NUM_FIFOS-1:0] fifo_empty_i,
  input logic [NUM_FIFOS-1:0] fifo_rd_i,
  input logic [NUM_FIFOS-1:0] fifo_wr_i,
  input logic                 ack_sm_err_i,
  input logic                 main_sm_err_i,
  input logic                 cntr_err_i,
  input logic                 inj_we_i,
  input logic [SEL_W-1:0]     inj_sel_i,
  input logic [ERR_W-1:0]     err_code_o,
  input logic                 alert_fatal_o,
  input logic                 irq_fatal_o
);

  localparam logic [ERR_W-1:0] MASK = impl_mask(NUM_FIFOS);

  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (err_code_o == '0) && !alert_fatal_o && !irq_fatal_o);

  p_wr_full_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (fifo_wr_i[0] && fifo_full_i[0]) |=> (err_code_o[POS_T_WR] && err_code_o[0]));

  p_rd_empty_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (fifo_rd_i[1] && fifo_empty_i[1]) |=> (err_code_o[POS_T_RD] && err_code_o[1]));

  p_both_flags_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (fifo_full_i[2] && fifo_empty_i[2]) |=> (err_code_o[POS_T_ST] && err_code_o[2]));

  p_sm_err_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    main_sm_err_i |=> err_code_o[POS_MAIN_SM]);

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((err_code_o & $past(err_code_o)) == $past(err_code_o)));

  p_inject_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (inj_we_i && inj_sel_i == SEL_W'(POS_CNTR)) |=> err_code_o[POS_CNTR]);

  p_reserved_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_code_o & ~MASK) == '0);

  p_alert_level_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    alert_fatal_o == (err_code_o != '0));

  p_irq_level_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_fatal_o == (err_code_o != '0));

endmodule

bind err_code_aggregator err_code_aggregator_chk #(.NUM_FIFOS(NUM_FIFOS)) u_chk (.*);

// File: tb/tb_err_code_aggregator.sv
module tb_err_code_aggregator;

  logic        clk_i = 1'b0;
  logic        rst_i;
  logic [2:0]  fifo_full_i, fifo_empty_i, fifo_rd_i, fifo_wr_i;
  logic        ack_sm_err_i, main_sm_err_i, cntr_err_i;
  logic        inj_we_i;
  logic [4:0]  inj_sel_i;
  logic [31:0] err_code_o;
  logic        alert_fatal_o, irq_fatal_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_code = '0;

  localparam logic [31:0] IMPL = 32'h7070_0007;

  err_code_aggregator dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] set_bits(
    input logic [2:0] f, input logic [2:0] e, input logic [2:0] r, input logic [2:0] w,
    input logic a, input logic m, input logic c, input logic we, input logic [4:0] sel);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 3; i++) begin
      if (w[i] && f[i]) begin s[28] = 1'b1; s[i] = 1'b1; end
      if (r[i] && e[i]) begin s[29] = 1'b1; s[i] = 1'b1; end
      if (f[i] && e[i]) begin s[30] = 1'b1; s[i] = 1'b1; end
    end
    s[20] = s[20] | a;
    s[21] = s[21] | m;
    s[22] = s[22] | c;
    if (we && IMPL[sel]) s[sel] = 1'b1;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    fifo_full_i = '0; fifo_empty_i = '0; fifo_rd_i = '0; fifo_wr_i = '0;
    ack_sm_err_i = 0; main_sm_err_i = 0; cntr_err_i = 0;
    inj_we_i = 0; inj_sel_i = '0;
  endtask

  // Inputs are set at negedge; one clock edge later the word reflects them.
  task automatic step(input string req);
    logic [31:0] nxt;
    nxt = exp_code | set_bits(fifo_full_i, fifo_empty_i, fifo_rd_i, fifo_wr_i,
                              ack_sm_err_i, main_sm_err_i, cntr_err_i, inj_we_i, inj_sel_i);
    @(posedge clk_i);
    @(negedge clk_i);
    exp_code = nxt;
    check(req, err_code_o, exp_code);
    check({req, " alert R9"}, {31'b0, alert_fatal_o}, {31'b0, exp_code != 0});
    check({req, " irq R10"}, {31'b0, irq_fatal_o}, {31'b0, exp_code != 0});
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    rst_i = 1'b0;
    exp_code = '0;
    check("R1 reset code", err_code_o, 32'h0);
    check("R1 reset alert", {30'b0, alert_fatal_o, irq_fatal_o}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst_i = 1'b1;
    @(negedge clk_i);
    do_reset();

    // R11: legal traffic sets nothing
    fifo_wr_i = 3'b111; fifo_rd_i = 3'b111; fifo_full_i = 3'b000; fifo_empty_i = 3'b000;
    step("R11 legal traffic");
    fifo_full_i = 3'b111; step("R11 full no strobe");

    // R2 per FIFO
    fifo_wr_i[1] = 1; fifo_full_i[1] = 1; step("R2 wr full gen");
    fifo_wr_i[2] = 1; fifo_full_i[2] = 1; step("R2 wr full out");
    do_reset();
    fifo_rd_i[0] = 1; fifo_empty_i[0] = 1; step("R3 rd empty reseed");
    do_reset();
    fifo_full_i[2] = 1; fifo_empty_i[2] = 1; step("R4 both flags out");
    do_reset();
    ack_sm_err_i = 1; step("R5 ack sm");
    main_sm_err_i = 1; step("R5 main sm");
    cntr_err_i = 1; step("R5 counter");
    step("R6 sticky hold");
    step("R6 sticky hold 2");

    // R7/R8 injection over every bit number
    for (int b = 0; b < 32; b++) begin
      do_reset();
      inj_we_i = 1; inj_sel_i = 5'(b);
      step(IMPL[b] ? "R7 inject" : "R8 reserved inject");
    end
    // R8 reserved injection leaves existing word unchanged
    do_reset();
    inj_we_i = 1; inj_sel_i = 5'd29; step("R7 inject type only");
    inj_we_i = 1; inj_sel_i = 5'd31; step("R8 reserved no change");
    inj_we_i = 0; inj_sel_i = 5'd0;  step("R7 select without strobe");

    // Random mix, sparse faults, periodic reset
    for (int it = 0; it < 400; it++) begin
      if (it % 10 == 0) do_reset();
      fifo_full_i  = 3'($urandom) & 3'($urandom);
      fifo_empty_i = 3'($urandom) & 3'($urandom) & ~fifo_full_i;
      if ($urandom % 8 == 0) fifo_empty_i = fifo_empty_i | fifo_full_i;
      fifo_rd_i    = 3'($urandom);
      fifo_wr_i    = 3'($urandom);
      ack_sm_err_i  = ($urandom % 16 == 0);
      main_sm_err_i = ($urandom % 16 == 0);
      cntr_err_i    = ($urandom % 16 == 0);
      inj_we_i      = ($urandom % 6 == 0);
      inj_sel_i     = 5'($urandom);
      step("R6 random mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule